// File: doc/BRIEF.md
# Four-Lane Deskew and Channel Aligner

This block sits behind four byte-wide receive lanes that have already been 8b/10b decoded. Each lane carries a byte plus a flag that marks it as a control character. Trace lengths and clock recovery leave the lanes skewed against each other by a number of byte times. The block removes that skew by lining up the align character that the transmitter sends on all lanes at once. The align character is the control code 8'h7C with the control flag set. Once the lanes are lined up, the four lanes leave as one 32-bit column per clock.

Each lane has its own small FIFO. A lane begins writing when its first align character arrives. The FIFOs are read in lockstep once every lane has started, so the lane that arrived early is held back by exactly its lead. A column monitor on the FIFO outputs counts align columns and drives a channel-aligned flag with hysteresis. Several consecutive aligned columns are needed to raise the flag. Several misaligned columns, with no aligned column between them, are needed to drop it. Byte synchronization from every lane gates the whole process.

Top module: `lane_deskew_top`

## Requirements
- R1: While and just after the active-high synchronous reset, `outValid` and `chanAligned` are 0 and every lane FIFO is empty.
- R2: A lane starts writing at its first align character (byte 8'h7C with its control bit set). The output column is lane i on `outData[8i+7:8i]` and `outCtrl[i]`. The first valid column holds the align character on all four lanes, and later columns keep each lane's input order.
- R3: The first valid column appears on the outputs one clock edge after the edge that samples the latest lane's align character. Columns then follow on every clock with no gap for as long as synchronization holds.
- R4: The FIFOs absorb a lead of up to FIFO_DEPTH-1 (15) byte times. A larger lead overflows the early lane's FIFO. In that case all FIFOs are flushed, no column is output, and alignment starts again at the next align characters.
- R5: No lane writes while any of the four `laneSync` bits is low. Align characters that arrive in that state are ignored.
- R6: `chanAligned` rises one clock after the fourth consecutive aligned column (align on all four lanes) appears at the outputs. A misaligned column before that point restarts the count.
- R7: While aligned, `chanAligned` falls one clock after the fourth misaligned column (align on some lanes but not all). Any aligned column in between resets that count.
- R8: When any `laneSync` bit is low at a clock edge, `chanAligned` and `outValid` are 0 after that edge and all FIFOs are flushed. Alignment then restarts from new align characters and needs four aligned columns again.
- R9: Valid columns that carry no align character on any lane change neither hysteresis count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst | input | 1 | Synchronous reset, active high |
| laneSync | input | 4 | Byte synchronization achieved, one bit per lane |
| laneData | input | 32 | Decoded bytes, lane i in bits 8i+7:8i |
| laneCtrl | input | 4 | Control-character flag per lane |
| outData | output | 32 | Deskewed column, lane i in bits 8i+7:8i |
| outCtrl | output | 4 | Control flags of the deskewed column |
| outValid | output | 1 | Column on outData/outCtrl is valid |
| chanAligned | output | 1 | Channel-aligned status with acquire and loss hysteresis |

## Verification
Lane streams are built from a column script and shifted per lane by a chosen skew. The scripts use several skew sets, including the largest lead the FIFOs can hold, so a wrong hold-back depth or a swapped lane shows up as a data mismatch. One script puts a misaligned column into the acquire run and interleaves aligned and misaligned columns after acquisition. This separates consecutive counting from simple totals and shows whether the loss count is reset. Further runs cover a lead one byte too long, align characters sent while one lane is unsynchronized, and a single-cycle synchronization drop. These show whether flush and restart happen, and whether the flag needs a full reacquisition.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  localparam int NUM_LANES = 4;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ALIGN_CHAR = 8'h7C;

  typedef struct packed {
    logic                 flush;
    logic                 rdEn;
    logic [NUM_LANES-1:0] wrEn;
  } fifoStrobes_t;
endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (rdEn) rdPtr <= nextPtr(rdPtr);
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4: control never writes a full FIFO unless it reads in the same cycle
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (wrEn && count == CNT_W'(DEPTH)) |-> rdEn);

  // R3: the lockstep read never finds a lane empty
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> (count != '0));
endmodule

// File: rtl/deskew_control.sv
module deskew_control
  import deskew_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LANES-1:0]        laneSync,
  input  logic [NUM_LANES*BYTE_W-1:0] inData,
  input  logic [NUM_LANES-1:0]        inCtrl,
  input  logic [NUM_LANES-1:0]        laneFull,
  output fifoStrobes_t                strobes,
  output logic                        allSync
);
  logic [NUM_LANES-1:0] seenAlign, isAlign, wantWr;
  logic readAll, overflow, doFlush;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_detect
    assign isAlign[g] = inCtrl[g] && (inData[g*BYTE_W +: BYTE_W] == ALIGN_CHAR);
  end

  assign allSync  = &laneSync;
  assign readAll  = &seenAlign;
  assign wantWr   = {NUM_LANES{allSync}} & (seenAlign | isAlign);
  assign overflow = (|(wantWr & laneFull)) && !readAll;
  assign doFlush  = !allSync || overflow;

  always_comb begin
    strobes.flush = doFlush;
    strobes.rdEn  = readAll && !doFlush;
    strobes.wrEn  = doFlush ? '0 : wantWr;
  end

  always_ff @(posedge clk) begin
    if (rst || doFlush) seenAlign <= '0;
    else                seenAlign <= seenAlign | (isAlign & {NUM_LANES{allSync}});
  end

  // R2: once a lane has started it stays started until a flush
  p_seen_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !strobes.flush |=> ((seenAlign & $past(seenAlign)) == $past(seenAlign)));
endmodule

// File: rtl/deskew_datapath.sv
module deskew_datapath
  import deskew_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LANES*BYTE_W-1:0] inData,
  input  logic [NUM_LANES-1:0]        inCtrl,
  input  fifoStrobes_t                strobes,
  output logic [NUM_LANES-1:0]        laneFull,
  output logic [NUM_LANES*BYTE_W-1:0] outData,
  output logic [NUM_LANES-1:0]        outCtrl,
  output logic                        outValid
);
  localparam int ENTRY_W = BYTE_W + 1;

  logic [ENTRY_W-1:0] headBus [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    deskew_lane_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk      (clk),
      .rst      (rst),
      .flush    (strobes.flush),
      .wrEn     (strobes.wrEn[g]),
      .rdEn     (strobes.rdEn),
      .wrData   ({inCtrl[g], inData[g*BYTE_W +: BYTE_W]}),
      .headData (headBus[g]),
      .full     (laneFull[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.flush) begin
      outValid <= 1'b0;
      outData  <= '0;
      outCtrl  <= '0;
    end else begin
      outValid <= strobes.rdEn;
      if (strobes.rdEn) begin
        for (int i = 0; i < NUM_LANES; i++) begin
          outData[i*BYTE_W +: BYTE_W] <= headBus[i][BYTE_W-1:0];
          outCtrl[i]                  <= headBus[i][BYTE_W];
        end
      end
    end
  end

  // R2: the first column after a start carries align on every lane
  p_first_col_align_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> ((&outCtrl) &&
      outData[0 +: BYTE_W] == ALIGN_CHAR && outData[BYTE_W +: BYTE_W] == ALIGN_CHAR &&
      outData[2*BYTE_W +: BYTE_W] == ALIGN_CHAR && outData[3*BYTE_W +: BYTE_W] == ALIGN_CHAR));
endmodule

// File: rtl/align_monitor.sv
module align_monitor
  import deskew_pkg::*;
#(
  parameter int ACQ_COLS  = 4,
  parameter int LOSS_COLS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        allSync,
  input  logic                        colValid,
  input  logic [NUM_LANES*BYTE_W-1:0] colData,
  input  logic [NUM_LANES-1:0]        colCtrl,
  output logic                        chanAligned
);
  localparam int MAX_COLS = (ACQ_COLS > LOSS_COLS) ? ACQ_COLS : LOSS_COLS;
  localparam int CNT_W    = $clog2(MAX_COLS + 1);

  logic [NUM_LANES-1:0] laneHasAlign;
  logic alignedCol, misalignedCol;
  logic [CNT_W-1:0] acqCnt, missCnt;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_col
    assign laneHasAlign[g] = colCtrl[g] && (colData[g*BYTE_W +: BYTE_W] == ALIGN_CHAR);
  end

  assign alignedCol    = colValid && (&laneHasAlign);
  assign misalignedCol = colValid && (|laneHasAlign) && !(&laneHasAlign);

  always_ff @(posedge clk) begin
    if (rst || !allSync) begin
      chanAligned <= 1'b0;
      acqCnt      <= '0;
      missCnt     <= '0;
    end else if (!chanAligned) begin
      if (alignedCol) begin
        if (acqCnt == CNT_W'(ACQ_COLS - 1)) begin
          chanAligned <= 1'b1;
          acqCnt      <= '0;
          missCnt     <= '0;
        end else begin
          acqCnt <= acqCnt + 1'b1;
        end
      end else if (misalignedCol) begin
        acqCnt <= '0;
      end
    end else begin
      if (alignedCol) begin
        missCnt <= '0;
      end else if (misalignedCol) begin
        if (missCnt == CNT_W'(LOSS_COLS - 1)) begin
          chanAligned <= 1'b0;
          missCnt     <= '0;
          acqCnt      <= '0;
        end else begin
          missCnt <= missCnt + 1'b1;
        end
      end
    end
  end

  // R6: acquisition follows an aligned column
  p_acquire_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(chanAligned) |-> $past(alignedCol));

  // R7: loss follows a misaligned column or a synchronization drop
  p_loss_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(chanAligned) |-> $past(misalignedCol || !allSync));
endmodule

// File: rtl/lane_deskew_top.sv
module lane_deskew_top
  import deskew_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ACQ_COLS   = 4,
  parameter int LOSS_COLS  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  laneSync,
  input  logic [31:0] laneData,
  input  logic [3:0]  laneCtrl,
  output logic [31:0] outData,
  output logic [3:0]  outCtrl,
  output logic        outValid,
  output logic        chanAligned
);
  fifoStrobes_t         strobes;
  logic                 allSync;
  logic [NUM_LANES-1:0] laneFull;

  deskew_control ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .laneSync (laneSync),
    .inData   (laneData),
    .inCtrl   (laneCtrl),
    .laneFull (laneFull),
    .strobes  (strobes),
    .allSync  (allSync)
  );

  deskew_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .inData   (laneData),
    .inCtrl   (laneCtrl),
    .strobes  (strobes),
    .laneFull (laneFull),
    .outData  (outData),
    .outCtrl  (outCtrl),
    .outValid (outValid)
  );

  align_monitor #(.ACQ_COLS(ACQ_COLS), .LOSS_COLS(LOSS_COLS)) mon_i (
    .clk         (clk),
    .rst         (rst),
    .allSync     (allSync),
    .colValid    (outValid),
    .colData     (outData),
    .colCtrl     (outCtrl),
    .chanAligned (chanAligned)
  );

  // R8: any lane losing sync clears flag and output valid on the next edge
  p_sync_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !(&laneSync) |=> (!chanAligned && !outValid));

  // R1: reset leaves outputs idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!outValid && !chanAligned));
endmodule

// File: tb/lane_deskew_top_tb_top.sv
module lane_deskew_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  laneSync = 4'h0;
  logic [31:0] laneData = {4{8'hBC}};
  logic [3:0]  laneCtrl = 4'hF;
  logic [31:0] outData;
  logic [3:0]  outCtrl;
  logic        outValid;
  logic        chanAligned;

  lane_deskew_top dut_i (
    .clk(clk), .rst(rst), .laneSync(laneSync), .laneData(laneData), .laneCtrl(laneCtrl),
    .outData(outData), .outCtrl(outCtrl), .outValid(outValid), .chanAligned(chanAligned)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] d;
    logic [3:0]  c;
    logic        f;
    int          k;
  } expCol_t;

  expCol_t sbQ[$];
  int      nChecks = 0;
  int      nFail = 0;
  longint  cyc = 0;
  bit      sbActive = 1'b0;
  longint  firstValidCyc = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic driveIdle();
    laneData = {4{8'hBC}};
    laneCtrl = 4'hF;
  endtask

  task automatic applyReset();
    rst = 1'b1;
    driveIdle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: pops expected columns while the scoreboard is active
  initial begin
    forever begin
      @(negedge clk);
      if (sbActive) begin
        if (outValid === 1'b1) begin
          if (firstValidCyc < 0) firstValidCyc = cyc;
          if (sbQ.size() > 0) begin
            expCol_t e;
            e = sbQ.pop_front();
            check({outCtrl, outData} === {e.c, e.d}, "R2", $sformatf("column %0d", e.k),
                  {28'd0, outCtrl, outData}, {28'd0, e.c, e.d});
            check(chanAligned === e.f, "R6/R7", $sformatf("flag at column %0d", e.k),
                  64'(chanAligned), 64'(e.f));
          end
        end else if (firstValidCyc >= 0 && sbQ.size() > 0) begin
          check(1'b0, "R3", "gap in column stream", 64'(outValid), 64'd1);
        end
      end
    end
  end

  // Driver: builds lane streams from a column script, pushes expected columns
  task automatic runScenario(input int sk0, input int sk1, input int sk2, input int sk3,
                             input string pat, input bit doReset, input bit expectOut);
    int sk[4];
    logic [8:0] seq[4][0:63];
    int len, maxSk, acq, miss;
    bit flag;
    longint aCyc;
    sk[0] = sk0; sk[1] = sk1; sk[2] = sk2; sk[3] = sk3;
    len = pat.len();
    maxSk = 0;
    acq = 0; miss = 0; flag = 1'b0; aCyc = 0;
    for (int i = 0; i < 4; i++) begin
      if (sk[i] > maxSk) maxSk = sk[i];
      for (int t = 0; t < 64; t++) seq[i][t] = 9'h1BC;
    end
    sbQ.delete();
    for (int k = 0; k < len; k++) begin
      expCol_t e;
      for (int i = 0; i < 4; i++) begin
        logic [8:0] v;
        if (pat[k] == "A" || (pat[k] == "M" && i == 0)) v = 9'h17C;
        else v = {1'b0, 8'((k * 7 + i * 31 + 5) & 8'hFF)};
        seq[i][sk[i] + k] = v;
        e.d[i*8 +: 8] = v[7:0];
        e.c[i] = v[8];
      end
      e.f = flag;
      e.k = k;
      if (expectOut) sbQ.push_back(e);
      // hysteresis expectation from R6, R7, R9
      if (!flag) begin
        if (pat[k] == "A") begin
          acq++;
          if (acq == 4) begin flag = 1'b1; acq = 0; miss = 0; end
        end else if (pat[k] == "M") acq = 0;
      end else begin
        if (pat[k] == "A") miss = 0;
        else if (pat[k] == "M") begin
          miss++;
          if (miss == 4) begin flag = 1'b0; miss = 0; acq = 0; end
        end
      end
    end
    if (doReset) applyReset();
    laneSync = 4'hF;
    firstValidCyc = -1;
    sbActive = 1'b1;
    for (int t = 0; t < maxSk + len; t++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        laneData[i*8 +: 8] = seq[i][t][7:0];
        laneCtrl[i]        = seq[i][t][8];
      end
      if (t == maxSk) aCyc = cyc;
    end
    @(negedge clk);
    driveIdle();
    repeat (4) @(negedge clk);
    sbActive = 1'b0;
    if (expectOut) begin
      check(sbQ.size() == 0, "R2", "columns not produced", 64'(sbQ.size()), 64'd0);
      check(firstValidCyc - aCyc == 2, "R3", "first column latency",
            64'(firstValidCyc - aCyc), 64'd2);
    end else begin
      check(firstValidCyc < 0, "R4", "output after overflow", 64'(firstValidCyc), 64'hFFFF_FFFF_FFFF_FFFF);
    end
    sbQ.delete();
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    bit sawValid;
    applyReset();
    @(negedge clk);
    // R1: reset state
    check(outValid === 1'b0, "R1", "outValid after reset", 64'(outValid), 64'd0);
    check(chanAligned === 1'b0, "R1", "chanAligned after reset", 64'(chanAligned), 64'd0);

    // R2, R3, R6, R9: skewed lanes, data columns between align columns
    runScenario(3, 0, 7, 5, "ADDADADDDADADDA", 1'b1, 1'b1);

    // R6, R7, R9: restart before acquire, loss-count reset, loss, reacquire needed
    runScenario(0, 2, 1, 4, "AADMAAADAAMDMDAMMMADMMMMDDA", 1'b1, 1'b1);

    // R4: largest lead that fits
    runScenario(15, 0, 8, 3, "AAAAD", 1'b1, 1'b1);

    // R4: lead one too large -> flush, no output, then retry succeeds
    runScenario(16, 0, 0, 0, "ADDD", 1'b1, 1'b0);
    runScenario(0, 0, 0, 0, "AAAADA", 1'b0, 1'b1);

    // R5: align characters while lane 2 is unsynchronized are ignored
    applyReset();
    laneSync = 4'b1011;
    sawValid = 1'b0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (t < 3) begin laneData = {4{8'h7C}}; laneCtrl = 4'hF; end
      else driveIdle();
      if (outValid !== 1'b0) sawValid = 1'b1;
    end
    repeat (3) begin
      @(negedge clk);
      if (outValid !== 1'b0) sawValid = 1'b1;
    end
    check(!sawValid, "R5", "output while unsynchronized", 64'(sawValid), 64'd0);
    runScenario(1, 0, 2, 0, "AADAA", 1'b0, 1'b1);

    // R8: single-cycle sync drop after acquisition
    runScenario(2, 5, 0, 1, "AAAAD", 1'b1, 1'b1);
    check(chanAligned === 1'b1, "R6", "aligned before sync drop", 64'(chanAligned), 64'd1);
    @(negedge clk);
    laneSync = 4'b1011;
    @(negedge clk);
    laneSync = 4'hF;
    check(chanAligned === 1'b0, "R8", "flag after sync drop", 64'(chanAligned), 64'd0);
    check(outValid === 1'b0, "R8", "valid after sync drop", 64'(outValid), 64'd0);
    sawValid = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (outValid !== 1'b0 || chanAligned !== 1'b0) sawValid = 1'b1;
    end
    check(!sawValid, "R8", "stale output after flush", 64'(sawValid), 64'd0);
    runScenario(2, 2, 0, 1, "AAAAAD", 1'b0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule